// File: doc/BRIEF.md
# Effective Memory-Access Mode Selector

This block decides under which privilege level, virtualization state and byte order one explicit data access runs, in a processor core that can host guest operating systems. An access normally takes the mode the hart is running in. Two override controls can replace that mode. A machine-level control, set while in machine mode, makes loads and stores behave as if the hart were at a saved privilege and virtualization state. A hypervisor-level control, set while in the hypervisor's supervisor mode, does the same using the hypervisor's own saved fields. Instruction fetches never take either override.

The selector reports whether the access goes through two-stage (guest) translation. It also picks the endianness bit that belongs to the effective mode, not to the current one. A separate path watches trap returns and produces a pulse that clears the hypervisor-level override when the return lands in a user mode or in guest supervisor mode. All results are registered, one cycle after the request.

Top module: `mem_mode_sel`

## Requirements
- R1: When `is_fetch`=1 the effective privilege and virtualization are the current ones, whatever the override controls hold.
- R2: A data access in machine mode (`cur_priv`=3) with `m_ovr`=1 takes privilege `m_prev_priv` and virtualization `m_prev_virt`. When `m_prev_priv`=3 the effective virtualization is 0.
- R3: A data access in machine mode with `m_ovr`=0 runs at privilege 3, virtualization 0.
- R4: A data access in hypervisor supervisor mode (`cur_priv`=1, `cur_virt`=0) with `h_ovr`=1 takes privilege 0 or 1 from `h_prev_spv` and virtualization `h_prev_virt`.
- R5: `h_ovr` has no effect in any mode other than hypervisor supervisor mode, including machine mode, where `m_ovr` alone decides.
- R6: Privilege encoding is 2 bits: user=0, supervisor=1, machine=3.
- R7: `two_stage` equals the effective virtualization bit.
- R8: `big_endian` is `be_m` at effective machine level, `be_hs` at supervisor with V=0, `be_vs` at supervisor with V=1, and `be_u` at user level with either V.
- R9: With parameter `VS_BE_FOLLOWS_HS`=1, guest supervisor accesses use `be_hs` and `be_vs` is ignored.
- R10: A return (`ret_valid`=1) whose target is user level (`ret_priv`=0) or has `ret_virt`=1 raises `h_ovr_clr` one cycle later. A return to hypervisor supervisor or machine mode does not.
- R11: `rsp_valid` follows `req_valid` with one cycle of latency, and results change only for a valid request.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| is_fetch | input | 1 | Request is an instruction fetch |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization mode |
| m_ovr | input | 1 | Machine-level data-access override enable |
| m_prev_priv | input | 2 | Machine-saved previous privilege |
| m_prev_virt | input | 1 | Machine-saved previous virtualization |
| h_ovr | input | 1 | Hypervisor-level data-access override enable |
| h_prev_virt | input | 1 | Hypervisor-saved previous virtualization |
| h_prev_spv | input | 1 | Hypervisor-saved previous privilege (0 user, 1 supervisor) |
| be_m | input | 1 | Machine-level big-endian |
| be_hs | input | 1 | Hypervisor supervisor big-endian |
| be_vs | input | 1 | Guest supervisor big-endian |
| be_u | input | 1 | User-level big-endian |
| ret_valid | input | 1 | Trap return executing |
| ret_priv | input | 2 | Privilege the return lands in |
| ret_virt | input | 1 | Virtualization the return lands in |
| rsp_valid | output | 1 | Result valid |
| eff_priv | output | 2 | Effective privilege |
| eff_virt | output | 1 | Effective virtualization |
| two_stage | output | 1 | Two-stage translation in effect |
| big_endian | output | 1 | Access is big-endian |
| h_ovr_clr | output | 1 | Clear pulse for the hypervisor-level override |

## Verification
A wrong choice between the two override sources shows one cycle after the request as a wrong `eff_priv` or `eff_virt`. The same error usually shows in `two_stage` and `big_endian` too, because the byte order and translation flag are derived from the effective mode rather than the current one. A missed or spurious clear of the hypervisor override shows as a wrong `h_ovr_clr` level in the cycle right after the return. Each case is checked on that very cycle, so a fault cannot hide behind later traffic.

// File: rtl/mem_mode_pkg.sv
package mem_mode_pkg;

  typedef enum logic [1:0] {
    PRV_USER = 2'd0,
    PRV_SUPV = 2'd1,
    PRV_RSVD = 2'd2,
    PRV_MACH = 2'd3
  } prv_e;

  typedef struct packed {
    prv_e prv;
    logic virt;
  } acc_mode_t;

  localparam int unsigned PRV_W = 2;

  // Mode saved by the machine level; a saved machine privilege is never virtual.
  function automatic acc_mode_t saved_m_mode(prv_e p, logic v);
    acc_mode_t r;
    r.prv  = p;
    r.virt = (p != PRV_MACH) && v;
    return r;
  endfunction

  // Mode saved by the hypervisor level: privilege is user or supervisor only.
  function automatic acc_mode_t saved_h_mode(logic spv, logic v);
    acc_mode_t r;
    r.prv  = spv ? PRV_SUPV : PRV_USER;
    r.virt = v;
    return r;
  endfunction

  // A return landing in user level or any virtual mode drops the hypervisor override.
  function automatic logic lands_below_hs(prv_e p, logic v);
    return (p == PRV_USER) || v;
  endfunction

  function automatic logic pick_endian(acc_mode_t m, logic bm, logic bhs,
                                       logic bvs, logic bu);
    logic r;
    case (m.prv)
      PRV_MACH: r = bm;
      PRV_SUPV: r = m.virt ? bvs : bhs;
      default:  r = bu;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mode_resolve.sv
module mode_resolve
  import mem_mode_pkg::*;
(
  input  logic       is_fetch,
  input  prv_e       cur_prv,
  input  logic       cur_virt,
  input  logic       m_ovr,
  input  prv_e       m_prev_prv,
  input  logic       m_prev_virt,
  input  logic       h_ovr,
  input  logic       h_prev_virt,
  input  logic       h_prev_spv,
  output acc_mode_t  eff,
  output logic       m_ovr_hit,
  output logic       h_ovr_hit
);

  logic in_mach;
  logic in_hs;
  acc_mode_t cur_mode;

  assign in_mach = (cur_prv == PRV_MACH);
  assign in_hs   = (cur_prv == PRV_SUPV) && !cur_virt;

  // Machine override wins in machine mode; hypervisor override only in HS.
  assign m_ovr_hit = !is_fetch && in_mach && m_ovr;
  assign h_ovr_hit = !is_fetch && in_hs && h_ovr;

  always_comb begin
    cur_mode.prv  = cur_prv;
    cur_mode.virt = in_mach ? 1'b0 : cur_virt;
    if (m_ovr_hit)      eff = saved_m_mode(m_prev_prv, m_prev_virt);
    else if (h_ovr_hit) eff = saved_h_mode(h_prev_spv, h_prev_virt);
    else                eff = cur_mode;
  end

endmodule

// File: rtl/endian_pick.sv
module endian_pick
  import mem_mode_pkg::*;
#(
  parameter bit VS_BE_FOLLOWS_HS = 1'b0
) (
  input  acc_mode_t eff,
  input  logic      be_m,
  input  logic      be_hs,
  input  logic      be_vs,
  input  logic      be_u,
  output logic      big_endian,
  output logic      two_stage
);

  logic vs_be_eff;

  generate
    if (VS_BE_FOLLOWS_HS) begin : g_vs_tied
      assign vs_be_eff = be_hs;
    end else begin : g_vs_own
      assign vs_be_eff = be_vs;
    end
  endgenerate

  assign big_endian = pick_endian(eff, be_m, be_hs, vs_be_eff, be_u);
  assign two_stage  = eff.virt;

endmodule

// File: rtl/ovr_return_clear.sv
module ovr_return_clear
  import mem_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ret_valid,
  input  prv_e ret_prv,
  input  logic ret_virt,
  output logic clr_q
);

  logic clr_event;

  assign clr_event = ret_valid && lands_below_hs(ret_prv, ret_virt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_event;
  end

  // R10
  ret_user_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_prv == PRV_USER) |=> clr_q);

  // R10
  ret_hs_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_prv == PRV_SUPV && !ret_virt) |=> !clr_q);

  // R10
  no_ret_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !clr_q);

endmodule

// File: rtl/mem_mode_sel.sv
module mem_mode_sel
  import mem_mode_pkg::*;
#(
  parameter bit VS_BE_FOLLOWS_HS = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       is_fetch,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic       m_ovr,
  input  logic [1:0] m_prev_priv,
  input  logic       m_prev_virt,
  input  logic       h_ovr,
  input  logic       h_prev_virt,
  input  logic       h_prev_spv,
  input  logic       be_m,
  input  logic       be_hs,
  input  logic       be_vs,
  input  logic       be_u,
  input  logic       ret_valid,
  input  logic [1:0] ret_priv,
  input  logic       ret_virt,
  output logic       rsp_valid,
  output logic [1:0] eff_priv,
  output logic       eff_virt,
  output logic       two_stage,
  output logic       big_endian,
  output logic       h_ovr_clr
);

  acc_mode_t eff_d;
  logic      m_ovr_hit;
  logic      h_ovr_hit;
  logic      be_d;
  logic      ts_d;

  mode_resolve u_resolve (
    .is_fetch    (is_fetch),
    .cur_prv     (prv_e'(cur_priv)),
    .cur_virt    (cur_virt),
    .m_ovr       (m_ovr),
    .m_prev_prv  (prv_e'(m_prev_priv)),
    .m_prev_virt (m_prev_virt),
    .h_ovr       (h_ovr),
    .h_prev_virt (h_prev_virt),
    .h_prev_spv  (h_prev_spv),
    .eff         (eff_d),
    .m_ovr_hit   (m_ovr_hit),
    .h_ovr_hit   (h_ovr_hit)
  );

  endian_pick #(.VS_BE_FOLLOWS_HS(VS_BE_FOLLOWS_HS)) u_endian (
    .eff        (eff_d),
    .be_m       (be_m),
    .be_hs      (be_hs),
    .be_vs      (be_vs),
    .be_u       (be_u),
    .big_endian (be_d),
    .two_stage  (ts_d)
  );

  ovr_return_clear u_retclr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_valid (ret_valid),
    .ret_prv   (prv_e'(ret_priv)),
    .ret_virt  (ret_virt),
    .clr_q     (h_ovr_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      eff_priv   <= '0;
      eff_virt   <= 1'b0;
      two_stage  <= 1'b0;
      big_endian <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        eff_priv   <= eff_d.prv;
        eff_virt   <= eff_d.virt;
        two_stage  <= ts_d;
        big_endian <= be_d;
      end
    end
  end

  // R1
  fetch_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(is_fetch)) |->
      (eff_priv == $past(cur_priv) && eff_virt == $past(cur_virt)));

  // R2
  m_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && m_ovr_hit) |=> (eff_priv == $past(m_prev_priv)));

  // R3
  m_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_fetch && cur_priv == 2'd3 && !m_ovr) |=>
      (eff_priv == 2'd3 && !eff_virt));

  // R5
  h_only_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ovr_hit |-> (cur_priv == 2'd1 && !cur_virt && !m_ovr_hit));

  // R5
  overrides_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m_ovr_hit, h_ovr_hit}) <= 1);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(eff_priv) && $stable(eff_virt) && $stable(big_endian)));

endmodule

// File: tb/mem_mode_sel_bench.sv
module mem_mode_sel_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit       vld;
    bit [1:0] prv;
    bit       virt;
    bit       be;
    bit       be_tied;
    bit       clr;
    string    tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, is_fetch = 0, cur_virt = 0, m_ovr = 0, m_prev_virt = 0;
  logic h_ovr = 0, h_prev_virt = 0, h_prev_spv = 0;
  logic be_m = 0, be_hs = 0, be_vs = 0, be_u = 0, ret_valid = 0, ret_virt = 0;
  logic [1:0] cur_priv = 0, m_prev_priv = 0, ret_priv = 0;
  logic rsp_valid, eff_virt, two_stage, big_endian, h_ovr_clr;
  logic [1:0] eff_priv;
  logic rsp_valid_t, eff_virt_t, two_stage_t, big_endian_t, h_ovr_clr_t;
  logic [1:0] eff_priv_t;

  int tests = 0;
  int fails = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_mode_sel u_mem_mode_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_fetch(is_fetch),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .m_ovr(m_ovr),
    .m_prev_priv(m_prev_priv), .m_prev_virt(m_prev_virt), .h_ovr(h_ovr),
    .h_prev_virt(h_prev_virt), .h_prev_spv(h_prev_spv), .be_m(be_m),
    .be_hs(be_hs), .be_vs(be_vs), .be_u(be_u), .ret_valid(ret_valid),
    .ret_priv(ret_priv), .ret_virt(ret_virt), .rsp_valid(rsp_valid),
    .eff_priv(eff_priv), .eff_virt(eff_virt), .two_stage(two_stage),
    .big_endian(big_endian), .h_ovr_clr(h_ovr_clr)
  );

  mem_mode_sel #(.VS_BE_FOLLOWS_HS(1'b1)) u_mem_mode_sel_tied (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_fetch(is_fetch),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .m_ovr(m_ovr),
    .m_prev_priv(m_prev_priv), .m_prev_virt(m_prev_virt), .h_ovr(h_ovr),
    .h_prev_virt(h_prev_virt), .h_prev_spv(h_prev_spv), .be_m(be_m),
    .be_hs(be_hs), .be_vs(be_vs), .be_u(be_u), .ret_valid(ret_valid),
    .ret_priv(ret_priv), .ret_virt(ret_virt), .rsp_valid(rsp_valid_t),
    .eff_priv(eff_priv_t), .eff_virt(eff_virt_t), .two_stage(two_stage_t),
    .big_endian(big_endian_t), .h_ovr_clr(h_ovr_clr_t)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model of the selection rules.
  task automatic drive(string tag, bit vld, bit fetch, bit [1:0] cp, bit cv,
                       bit mo, bit [1:0] mp, bit mv, bit ho, bit hv, bit hs,
                       bit [3:0] be, bit rv, bit [1:0] rp, bit rvi);
    exp_t e;
    bit [1:0] p;
    bit v;
    bit vs_be;
    @(negedge clk);
    req_valid = vld; is_fetch = fetch; cur_priv = cp; cur_virt = cv;
    m_ovr = mo; m_prev_priv = mp; m_prev_virt = mv;
    h_ovr = ho; h_prev_virt = hv; h_prev_spv = hs;
    {be_m, be_hs, be_vs, be_u} = be;
    ret_valid = rv; ret_priv = rp; ret_virt = rvi;
    p = cp; v = (cp == 2'd3) ? 1'b0 : cv;
    if (!fetch) begin
      if (cp == 2'd3) begin
        if (mo) begin p = mp; v = (mp == 2'd3) ? 1'b0 : mv; end
      end else if (cp == 2'd1 && !cv && ho) begin
        p = hs ? 2'd1 : 2'd0; v = hv;
      end
    end
    e.vld = vld; e.prv = p; e.virt = v; e.tag = tag;
    vs_be = be[1];
    e.be = (p == 2'd3) ? be[3] : (p == 2'd1) ? (v ? vs_be : be[2]) : be[0];
    e.be_tied = (p == 2'd3) ? be[3] : (p == 2'd1) ? be[2] : be[0];
    e.clr = rv && (rp == 2'd0 || rvi);
    q.push_back(e);
  endtask

  // Monitor: compare one cycle after each drive, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R11", {e.tag, " rsp_valid"}, rsp_valid, e.vld);
        check("R10", {e.tag, " h_ovr_clr"}, h_ovr_clr, e.clr);
        if (e.vld) begin
          check("R2/R4", {e.tag, " eff_priv"}, eff_priv, e.prv);
          check("R2/R4", {e.tag, " eff_virt"}, eff_virt, e.virt);
          check("R7", {e.tag, " two_stage"}, two_stage, e.virt);
          check("R8", {e.tag, " big_endian"}, big_endian, e.be);
          check("R9", {e.tag, " big_endian tied"}, big_endian_t, e.be_tied);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12", "rsp_valid", rsp_valid, 0);
    check("R12", "eff_priv", eff_priv, 0);
    check("R12", "big_endian", big_endian, 0);
    check("R12", "h_ovr_clr", h_ovr_clr, 0);
    @(negedge clk);
    rst_n = 1;
    // be order: {m, hs, vs, u}
    drive("R1 fetch ignores m_ovr", 1, 1, 2'd3, 0, 1, 2'd0, 1, 0, 0, 0, 4'b1000, 0, 0, 0);
    drive("R1 fetch in HS ignores h_ovr", 1, 1, 2'd1, 0, 0, 2'd0, 0, 1, 1, 0, 4'b0100, 0, 0, 0);
    drive("R2 m_ovr to VU", 1, 0, 2'd3, 0, 1, 2'd0, 1, 0, 0, 0, 4'b0001, 0, 0, 0);
    drive("R2 m_ovr to VS", 1, 0, 2'd3, 0, 1, 2'd1, 1, 0, 0, 0, 4'b0010, 0, 0, 0);
    drive("R2 m_ovr to M drops V", 1, 0, 2'd3, 0, 1, 2'd3, 1, 0, 0, 0, 4'b0111, 0, 0, 0);
    drive("R3 plain M", 1, 0, 2'd3, 0, 0, 2'd0, 1, 1, 1, 0, 4'b1011, 0, 0, 0);
    drive("R5 M ignores h_ovr", 1, 0, 2'd3, 0, 0, 2'd1, 1, 1, 1, 1, 4'b0110, 0, 0, 0);
    drive("R4 HS h_ovr to VU", 1, 0, 2'd1, 0, 0, 2'd0, 0, 1, 1, 0, 4'b1110, 0, 0, 0);
    drive("R4 HS h_ovr to VS", 1, 0, 2'd1, 0, 0, 2'd0, 0, 1, 1, 1, 4'b1010, 0, 0, 0);
    drive("R4 HS h_ovr to HS", 1, 0, 2'd1, 0, 0, 2'd0, 0, 1, 0, 1, 4'b0101, 0, 0, 0);
    drive("R4 HS no ovr", 1, 0, 2'd1, 0, 1, 2'd3, 1, 0, 1, 0, 4'b0100, 0, 0, 0);
    drive("R5 VS ignores h_ovr", 1, 0, 2'd1, 1, 1, 2'd3, 0, 1, 0, 0, 4'b0010, 0, 0, 0);
    drive("R5 U ignores both", 1, 0, 2'd0, 0, 1, 2'd3, 0, 1, 1, 1, 4'b1101, 0, 0, 0);
    drive("R6 VU plain", 1, 0, 2'd0, 1, 0, 2'd0, 0, 0, 0, 0, 4'b0001, 0, 0, 0);
    drive("R11 idle", 0, 0, 2'd3, 0, 0, 2'd0, 0, 0, 0, 0, 4'b1111, 0, 0, 0);
    drive("R10 ret to U", 0, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 4'b0000, 1, 2'd0, 0);
    drive("R10 ret to VS", 0, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 4'b0000, 1, 2'd1, 1);
    drive("R10 ret to HS", 0, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 4'b0000, 1, 2'd1, 0);
    drive("R10 ret to M", 0, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 4'b0000, 1, 2'd3, 0);
    drive("R10 ret to VU with access", 1, 0, 2'd1, 1, 0, 2'd0, 0, 0, 0, 0, 4'b0010, 1, 2'd0, 1);
    drive("R9 VS be_vs differs", 1, 0, 2'd1, 1, 0, 2'd0, 0, 0, 0, 0, 4'b0110, 0, 0, 0);
    drive("R9 VS be_hs differs", 1, 0, 2'd1, 1, 0, 2'd0, 0, 0, 0, 0, 4'b0100, 0, 0, 0);
    drive("flush", 0, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 4'b0000, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule